// File: doc/BRIEF.md
# DAC Power and Reference Controller

This block governs the power state and reference selection of a two-channel voltage DAC. It receives already-decoded commands (a 4-bit code, a channel address, a 16-bit data word and a one-cycle valid strobe). From these it keeps one power-down flag per channel, the reference selection (internal or external), and why the internal reference is off. It drives a per-channel enable, a reference enable, a reference-select output, a bias enable and a settling-busy flag that marks the power-up delay of a channel that has just been woken.

The internal reference can be off for two different reasons, and the reason decides what can wake it. If it was switched off by selecting the external reference, only an explicit internal-select command brings it back. If it was switched off by the whole-chip shutdown, any update command that reaches a channel also wakes it. The wake-up delay of a channel is longer when, before the command, every channel and the reference were off, because the shared bias is then off as well. Delays are given in microseconds and converted into cycle counts with the clock-frequency parameter.

The design is built from three kinds of state machine. Each channel has its own machine with states CH_ON and CH_OFF. CH_ON goes to CH_OFF on a channel power-down aimed at it or on a chip shutdown. CH_OFF goes back to CH_ON on an update aimed at it. The reference machine has the states REF_ON, REF_OFF_EXT and REF_OFF_CHIP:
- REF_ON goes to REF_OFF_EXT on external select, and to REF_OFF_CHIP on chip shutdown.
- REF_OFF_EXT goes to REF_ON only on internal select.
- REF_OFF_CHIP goes to REF_ON on internal select or on an update that hits a channel, and to REF_OFF_EXT on external select.

The settle timer has the states TS_IDLE and TS_SETTLE. TS_IDLE goes to TS_SETTLE when a powered-down channel is woken. TS_SETTLE reloads on a new wake, and returns to TS_IDLE when its count runs out.

Top module: `dac_pwr_ref_ctrl`

## Requirements
- R1: After reset all channel enables are 1, settle_busy is 0, and the reference is on with ref_ext 0 when INT_REF_DEFAULT is 1, or off with ref_ext 1 when it is 0.
- R2: Code 4'b0100 clears the enable of the channel whose address equals its index (0 or 1), or of both channels when the address equals ALL_ADDR (default 4'hF); any other address changes nothing.
- R3: Code 4'b0101 clears both channel enables and turns the internal reference off, whatever the address.
- R4: Code 4'b0110 selects the internal reference (ref_ext 0) and turns it on (ref_en 1), from any reference state.
- R5: Code 4'b0111 selects the external reference (ref_ext 1, ref_en 0); after that, updates and 4'b0101 leave ref_en at 0 until a 4'b0110 arrives.
- R6: An update code (a code whose bit is set in UPD_MASK, default codes 1, 2 and 3) sets the enable of each addressed channel, using the same address decoding as R2.
- R7: When the reference was turned off by 4'b0101 and is still internally selected, an update code that addresses at least one channel turns ref_en back on.
- R8: bias_en is 0 exactly when both channels are powered down and ref_en is 0.
- R9: When an update wakes at least one powered-down channel while bias_en is 1, settle_busy is 1 for exactly SHORT_US*CLK_MHZ cycles (2000 by default) from the cycle after the command.
- R10: When such an update arrives while bias_en is 0, settle_busy is 1 for exactly LONG_US*CLK_MHZ cycles (2400 by default).
- R11: The data word has no effect on any state; codes outside 4..7 that are not update codes, and cycles with cmd_valid at 0, change nothing.
- R12: A new wake during an active delay restarts the count with the length chosen for the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 4 | Channel address (channel index or ALL_ADDR) |
| cmd_data | input | 16 | Data word, not used by this block |
| ch_en | output | 2 | Per-channel power enable |
| ref_en | output | 1 | Internal reference enable |
| ref_ext | output | 1 | External reference selected |
| bias_en | output | 1 | Shared bias enable |
| settle_busy | output | 1 | Power-up settling delay in progress |

## Verification
The assertions assume that code, address and data carry known values whenever cmd_valid is high. They also assume that UPD_MASK does not contain the four power and reference codes, so that no code is both an update and a power command. The bench draws only fully defined values from a seeded generator. It keeps the default mask, and it sends update codes only through the set that mask defines. Between commands the strobe may be high on consecutive cycles, so commands can arrive back to back during a settle window, and the bench model allows for this.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam logic [3:0] CODE_PD_CHAN = 4'b0100;
    localparam logic [3:0] CODE_PD_CHIP = 4'b0101;
    localparam logic [3:0] CODE_REF_INT = 4'b0110;
    localparam logic [3:0] CODE_REF_EXT = 4'b0111;

    typedef enum logic [1:0] {
        REF_ON       = 2'd0,
        REF_OFF_EXT  = 2'd1,
        REF_OFF_CHIP = 2'd2
    } ref_state_e;

    typedef enum logic {
        CH_ON  = 1'b0,
        CH_OFF = 1'b1
    } ch_state_e;

    typedef enum logic {
        TS_IDLE   = 1'b0,
        TS_SETTLE = 1'b1
    } settle_state_e;

endpackage

// File: rtl/dpr_chan_fsm.sv
module dpr_chan_fsm
    import dpr_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int          IDX      = 0,
    parameter logic [ADDR_W-1:0] ALL_ADDR = '1,
    parameter logic [15:0] UPD_MASK = 16'h000E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              hit,
    output logic              pd,
    output logic              wake
);

    ch_state_e state_q, state_d;
    logic is_upd;

    always_comb begin
        hit    = (cmd_addr == ADDR_W'(IDX)) || (cmd_addr == ALL_ADDR);
        is_upd = UPD_MASK[cmd_code];
    end

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (state_q)
                CH_ON: begin
                    if (cmd_code == CODE_PD_CHIP ||
                        (cmd_code == CODE_PD_CHAN && hit))
                        state_d = CH_OFF;
                end
                CH_OFF: begin
                    if (is_upd && hit)
                        state_d = CH_ON;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        pd   = (state_q == CH_OFF);
        wake = (state_q == CH_OFF) && cmd_valid && is_upd && hit;
    end

    assert_pd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_PD_CHAN && hit) |=> pd);

    assert_upd_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_upd && hit) |=> !pd);

endmodule

// File: rtl/dpr_ref_fsm.sv
module dpr_ref_fsm
    import dpr_pkg::*;
#(
    parameter logic INT_REF_DEFAULT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic       upd_hit,
    output logic       ref_en,
    output logic       ref_ext
);

    localparam ref_state_e RST_STATE = INT_REF_DEFAULT ? REF_ON : REF_OFF_EXT;

    ref_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (state_q)
                REF_ON: begin
                    if (cmd_code == CODE_REF_EXT)      state_d = REF_OFF_EXT;
                    else if (cmd_code == CODE_PD_CHIP) state_d = REF_OFF_CHIP;
                end
                REF_OFF_EXT: begin
                    if (cmd_code == CODE_REF_INT)      state_d = REF_ON;
                end
                REF_OFF_CHIP: begin
                    if (cmd_code == CODE_REF_INT)      state_d = REF_ON;
                    else if (cmd_code == CODE_REF_EXT) state_d = REF_OFF_EXT;
                    else if (upd_hit)                  state_d = REF_ON;
                end
                default: state_d = RST_STATE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        ref_en  = (state_q == REF_ON);
        ref_ext = (state_q == REF_OFF_EXT);
    end

    assert_ext_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ext && !(cmd_valid && cmd_code == CODE_REF_INT)) |=> (ref_ext && !ref_en));

    assert_int_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_REF_INT) |=> (ref_en && !ref_ext));

    assert_chip_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REF_OFF_CHIP && upd_hit && cmd_code != CODE_REF_EXT) |=> ref_en);

endmodule

// File: rtl/dpr_settle_timer.sv
module dpr_settle_timer
    import dpr_pkg::*;
#(
    parameter int SHORT_CYC = 2000,
    parameter int LONG_CYC  = 2400,
    localparam int MAX_CYC  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy
);

    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LONG_CYC - 1);

    settle_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TS_IDLE: begin
                if (start) begin
                    state_d = TS_SETTLE;
                    cnt_d   = long_sel ? LOAD_LONG : LOAD_SHORT;
                end
            end
            TS_SETTLE: begin
                if (start) begin
                    cnt_d = long_sel ? LOAD_LONG : LOAD_SHORT;
                end else if (cnt_q == '0) begin
                    state_d = TS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = TS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb busy = (state_q == TS_SETTLE);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> busy);

    assert_long_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && long_sel) |=> (busy && cnt_q == LOAD_LONG));

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !long_sel) |=> (busy && cnt_q == LOAD_SHORT));

endmodule

// File: rtl/dac_pwr_ref_ctrl.sv
module dac_pwr_ref_ctrl
    import dpr_pkg::*;
#(
    parameter int          NUM_CH          = 2,
    parameter int          ADDR_W          = 4,
    parameter int          DATA_W          = 16,
    parameter logic [ADDR_W-1:0] ALL_ADDR  = 4'hF,
    parameter logic [15:0] UPD_MASK        = 16'h000E,
    parameter logic        INT_REF_DEFAULT = 1'b1,
    parameter int          CLK_MHZ         = 200,
    parameter int          SHORT_US        = 10,
    parameter int          LONG_US         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [NUM_CH-1:0] ch_en,
    output logic              ref_en,
    output logic              ref_ext,
    output logic              bias_en,
    output logic              settle_busy
);

    localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
    localparam int LONG_CYC  = LONG_US * CLK_MHZ;

    logic [NUM_CH-1:0] ch_hit, ch_pd, ch_wake;
    logic upd_hit, bias_off, wake_any;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dpr_chan_fsm #(
            .ADDR_W   (ADDR_W),
            .IDX      (g),
            .ALL_ADDR (ALL_ADDR),
            .UPD_MASK (UPD_MASK)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_valid (cmd_valid),
            .cmd_code  (cmd_code),
            .cmd_addr  (cmd_addr),
            .hit       (ch_hit[g]),
            .pd        (ch_pd[g]),
            .wake      (ch_wake[g])
        );
    end

    always_comb begin
        upd_hit  = cmd_valid && UPD_MASK[cmd_code] && (|ch_hit);
        wake_any = |ch_wake;
        bias_off = (&ch_pd) && !ref_en;
        ch_en    = ~ch_pd;
        bias_en  = !bias_off;
    end

    dpr_ref_fsm #(
        .INT_REF_DEFAULT (INT_REF_DEFAULT)
    ) ref_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .upd_hit   (upd_hit),
        .ref_en    (ref_en),
        .ref_ext   (ref_ext)
    );

    dpr_settle_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wake_any),
        .long_sel (bias_off),
        .busy     (settle_busy)
    );

    assert_inputs_known_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$isunknown({cmd_code, cmd_addr, cmd_data}));

    assert_chip_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_PD_CHIP) |=> (!ref_en && ch_en == '0 && !bias_en));

    assert_wake_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && UPD_MASK[cmd_code] && (|(ch_hit & ~ch_en))) |=> settle_busy);

endmodule

// File: tb/dac_pwr_ref_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_pwr_ref_ctrl_tb_top;

    localparam int SHORT_N = 10 * 200;
    localparam int LONG_N  = 12 * 200;
    localparam logic [3:0] ALL = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [3:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [1:0]  ch_en;
    logic        ref_en, ref_ext, bias_en, settle_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_pwr_ref_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .ch_en(ch_en), .ref_en(ref_en),
        .ref_ext(ref_ext), .bias_en(bias_en), .settle_busy(settle_busy)
    );

    // Bench model: m_ref 0 = on, 1 = off by external select, 2 = off by chip shutdown
    logic [1:0] m_pd;
    int         m_ref;
    int         m_cnt;

    function automatic bit is_update(input logic [3:0] c);
        return (c == 4'd1) || (c == 4'd2) || (c == 4'd3);
    endfunction

    function automatic int delay_for(input bit long_sel);
        return long_sel ? LONG_N : SHORT_N;
    endfunction

    function automatic bit exp_bias(input logic [1:0] pd, input int rs);
        return !((pd == 2'b11) && (rs != 0));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pd  <= 2'b00;
            m_ref <= 0;
            m_cnt <= 0;
        end else begin
            logic [1:0] hit;
            logic [1:0] npd;
            int nref;
            int ncnt;
            hit[0] = (cmd_addr == 4'd0) || (cmd_addr == ALL);
            hit[1] = (cmd_addr == 4'd1) || (cmd_addr == ALL);
            npd  = m_pd;
            nref = m_ref;
            ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (cmd_valid) begin
                if (cmd_code == 4'b0100) npd = m_pd | hit;
                else if (cmd_code == 4'b0101) begin
                    npd = 2'b11;
                    if (m_ref == 0) nref = 2;
                end
                else if (cmd_code == 4'b0110) nref = 0;
                else if (cmd_code == 4'b0111) nref = 1;
                else if (is_update(cmd_code) && (hit != 2'b00)) begin
                    if ((m_pd & hit) != 2'b00)
                        ncnt = delay_for(!exp_bias(m_pd, m_ref));
                    npd = m_pd & ~hit;
                    if (m_ref == 2) nref = 0;
                end
            end
            m_pd  <= npd;
            m_ref <= nref;
            m_cnt <= ncnt;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Every-cycle comparison with the bench model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ch_en == ~m_pd, "R2/R3/R6 ch_en", int'(ch_en), int'(~m_pd));
            chk(ref_en == (m_ref == 0), "R4/R5/R7 ref_en", int'(ref_en), int'(m_ref == 0));
            chk(ref_ext == (m_ref == 1), "R5 ref_ext", int'(ref_ext), int'(m_ref == 1));
            chk(bias_en == exp_bias(m_pd, m_ref), "R8 bias_en", int'(bias_en),
                int'(exp_bias(m_pd, m_ref)));
            chk(settle_busy == (m_cnt > 0), "R9/R10/R12 settle_busy", int'(settle_busy),
                int'(m_cnt > 0));
        end
    end

    task automatic send(input logic [3:0] c, input logic [3:0] a);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_addr  = a;
        cmd_data  = 16'($urandom);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = 16'($urandom);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (settle_busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ch_en == 2'b11, "R1 ch_en", int'(ch_en), 3);
        chk(ref_en == 1'b1 && ref_ext == 1'b0, "R1 ref", int'({ref_en, ref_ext}), 2);
        chk(settle_busy == 1'b0, "R1 busy", int'(settle_busy), 0);

        // R2: single channel power-down; foreign address ignored
        send(4'b0100, 4'd0);
        chk(ch_en == 2'b10, "R2 pd ch0", int'(ch_en), 2);
        send(4'b0100, 4'd5);
        chk(ch_en == 2'b10, "R2 other addr", int'(ch_en), 2);

        // R6 + R9: update wakes ch0, short delay
        send(4'b0011, 4'd0);
        chk(ch_en == 2'b11, "R6 wake ch0", int'(ch_en), 3);
        measure_busy(n);
        chk(n == SHORT_N, "R9 short delay", n, SHORT_N);

        // R3 + R8: chip shutdown
        send(4'b0101, 4'd3);
        chk(ch_en == 2'b00 && !ref_en, "R3 chip off", int'({ch_en, ref_en}), 0);
        chk(bias_en == 1'b0, "R8 bias off", int'(bias_en), 0);

        // R11: unlisted code and idle cycles change nothing
        send(4'b1001, ALL);
        repeat (3) @(negedge clk);
        chk(ch_en == 2'b00 && !ref_en && !settle_busy, "R11 no effect",
            int'({ch_en, ref_en, settle_busy}), 0);

        // R7 + R10: update restores reference after chip shutdown, long delay
        send(4'b0001, 4'd1);
        chk(ref_en == 1'b1 && ch_en == 2'b10, "R7 ref wake", int'({ch_en, ref_en}), 5);
        measure_busy(n);
        chk(n == LONG_N, "R10 long delay", n, LONG_N);

        // R5: external select is sticky
        send(4'b0111, 4'd0);
        chk(ref_ext == 1'b1 && ref_en == 1'b0, "R5 ext sel", int'({ref_en, ref_ext}), 1);
        send(4'b0011, ALL);
        chk(ref_en == 1'b0, "R5 update keeps ref off", int'(ref_en), 0);
        send(4'b0101, 4'd0);
        send(4'b0011, 4'd0);
        chk(ref_en == 1'b0 && ref_ext == 1'b1, "R5 chip+update keeps ref off",
            int'({ref_en, ref_ext}), 1);
        measure_busy(n);

        // R4: internal select
        send(4'b0110, 4'd0);
        chk(ref_en == 1'b1 && ref_ext == 1'b0, "R4 int sel", int'({ref_en, ref_ext}), 2);

        // R12: restart during settling
        send(4'b0100, ALL);
        chk(bias_en == 1'b1, "R8 bias on with ref", int'(bias_en), 1);
        send(4'b0011, 4'd0);
        repeat (500) @(negedge clk);
        send(4'b0011, 4'd1);
        measure_busy(n);
        chk(n == SHORT_N, "R12 restart", n, SHORT_N);

        // Constrained random phase (checked every cycle against the model)
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) begin
                int k;
                k = int'($urandom % 8);
                cmd_valid = 1'b1;
                cmd_code  = (k == 0) ? 4'($urandom) : 4'(k);
                case ($urandom % 4)
                    0: cmd_addr = 4'd0;
                    1: cmd_addr = 4'd1;
                    2: cmd_addr = ALL;
                    default: cmd_addr = 4'($urandom);
                endcase
            end else begin
                cmd_valid = 1'b0;
            end
            cmd_data = 16'($urandom);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule